// File: doc/BRIEF.md
# ADC Conversion Sequencer

This block sits between a host register interface and one multiplexed analog-to-digital converter that serves ten inputs. Inputs 0 to 7 are differential channels. Inputs 8 and 9 are reference inputs: one is tied to +10 V and the other to 0 V, so software can calibrate gain and offset. The host writes a control word that names an input, carries a per-input enable mask, can ask for a settling delay, and holds a start bit. The sequencer checks that the named input is enabled. It waits out the settling delay when that was requested. It then issues one conversion request to the converter and captures the returned sample.

Each finished conversion stores the sample in a result register and sets a done flag in the status register. The done flag raises the interrupt line when its enable bit is set. The host clears the flag by writing a one to it. The converter side has two valid/ready channels. On the request channel the sequencer sends the input number. The converter may hold ready low for as long as it likes. The sequencer then keeps valid high and the input number unchanged until the transfer. On the result channel the converter sends the sample. The sequencer raises ready only while it waits for a result, so at most one conversion is in flight at any time. A held-off result simply stalls the sequencer in its wait state.

Register addresses on the host port are 0 control, 1 status, 2 interrupt enable, 3 result, and 4 result in offset binary. A write happens on a clock edge when `host_wr` is high. Reads are combinational from `host_addr`.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, every readable register reads 0, except address 4, which reads 0x8000. Both valid/ready outputs and `irq` are low.
- R2: A control write with bit 0 set launches a conversion. Bits 4:1 hold the input number (0 to 9). Bits 14:5 are the enable mask, with bit 5+n enabling input n. Bit 15 is the delay flag. With the flag clear and the input enabled, `conv_req_valid` is high on the second rising edge after the write edge, and `conv_chan` equals bits 4:1.
- R3: The start bit clears itself when the conversion launches. A later read of the control register shows bit 0 as 0 and keeps the other fields as written.
- R4: While `conv_req_valid` is high and `conv_req_ready` is low, valid stays high and `conv_chan` holds its value.
- R5: `res_ready` is high only while a result is awaited and never together with `conv_req_valid`. A result transfer stores `res_data` in the result register (address 3) and sets status bit 2 (mask 0x4).
- R6: Address 4 reads the result with its most significant bit inverted. This is the offset-binary form for the ±10 V range.
- R7: If the enable-mask bit for the selected input is clear, or the input number is above 9, no request is issued. Status bit 2 still sets, and the result register keeps its value.
- R8: With the delay flag set, the request is issued SETTLE_CYCLES cycles later than it would be without the flag.
- R9: A control write while a conversion is pending or in flight is ignored as a whole. It launches nothing, and the control register keeps its earlier content.
- R10: Writing status with bit 2 set clears the done flag. Writing status with bit 2 clear leaves it unchanged. A completion in the same cycle as a clear leaves the flag set.
- R11: `irq` is high exactly while the done flag and bit 2 of the interrupt-enable register (address 2) are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Register write strobe |
| host_addr | input | 3 | Register address |
| host_wdata | input | 16 | Write data |
| host_rdata | output | 16 | Read data for host_addr |
| conv_req_valid | output | 1 | Conversion request valid |
| conv_req_ready | input | 1 | Converter accepts request |
| conv_chan | output | 4 | Input number to convert |
| res_valid | input | 1 | Converter result valid |
| res_ready | output | 1 | Sequencer accepts result |
| res_data | input | 16 | Converter sample, two's complement |
| irq | output | 1 | Conversion-done interrupt |

## Verification
The bench builds the block with SETTLE_CYCLES set to 20 instead of the default 1000. This keeps the delayed path short enough to measure its exact launch latency against the undelayed path. NUM_IN and the data width stay at their defaults of 10 and 16. With those defaults, both reference inputs and a select value above the input range can be reached, and so can the sign-boundary samples 0x7FFF and 0x8000. The converter model stalls both the request handshake and the result handshake by several cycles. This exposes the hold rule under back-pressure and the window in which a second control write has to be ignored.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] A_STATUS = 3'd1;
  localparam logic [ADDR_W-1:0] A_IRQEN  = 3'd2;
  localparam logic [ADDR_W-1:0] A_RESULT = 3'd3;
  localparam logic [ADDR_W-1:0] A_RES_OB = 3'd4;

  // status / interrupt-enable bit used by the done flag
  localparam int DONE_BIT = 2;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SETTLE,
    ST_REQ,
    ST_WAIT
  } seq_state_e;

endpackage

// File: rtl/adc_seq_settle.sv
module adc_seq_settle #(
  parameter int CYCLES = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic run,
  output logic zero
);
  localparam int CNT_W = $clog2(CYCLES + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= CNT_W'(CYCLES - 1);
    end else if (run && (cnt_q != '0)) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/adc_seq_regs.sv
module adc_seq_regs
  import adc_seq_pkg::*;
#(
  parameter int NUM_IN = 10,
  parameter int DATA_W = 16,
  parameter int REG_W  = 16,
  parameter int SEL_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [REG_W-1:0]  host_wdata,
  output logic [REG_W-1:0]  host_rdata,
  // towards the sequencer
  output logic              start_pend,
  output logic [SEL_W-1:0]  sel,
  output logic [NUM_IN-1:0] mask,
  output logic              dly_req,
  // from the sequencer
  input  logic              launch,
  input  logic              busy,
  input  logic              done_set,
  input  logic              cap_en,
  input  logic [DATA_W-1:0] cap_data,
  // flags
  output logic              done_flag,
  output logic              ie_done,
  output logic [DATA_W-1:0] result_val,
  output logic              irq
);
  localparam int CTRL_W  = SEL_W + NUM_IN + 2;
  localparam int SEL_LO  = 1;
  localparam int MASK_LO = SEL_W + 1;
  localparam int DLY_POS = SEL_W + NUM_IN + 1;

  logic              start_q;
  logic [SEL_W-1:0]  sel_q;
  logic [NUM_IN-1:0] mask_q;
  logic              dly_q;
  logic              ie_q;
  logic              done_q;
  logic [DATA_W-1:0] result_q;

  logic ctrl_wr;
  logic clr_wr;
  logic ie_wr;

  // a new control word is taken only when nothing is pending or running
  assign ctrl_wr = host_wr && (host_addr == A_CTRL) && !busy && !start_q;
  assign clr_wr  = host_wr && (host_addr == A_STATUS) && host_wdata[DONE_BIT];
  assign ie_wr   = host_wr && (host_addr == A_IRQEN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_q <= 1'b0;
      sel_q   <= '0;
      mask_q  <= '0;
      dly_q   <= 1'b0;
    end else if (launch) begin
      start_q <= 1'b0;
    end else if (ctrl_wr) begin
      start_q <= host_wdata[0];
      sel_q   <= host_wdata[SEL_LO +: SEL_W];
      mask_q  <= host_wdata[MASK_LO +: NUM_IN];
      dly_q   <= host_wdata[DLY_POS];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ie_q <= 1'b0;
    end else if (ie_wr) begin
      ie_q <= host_wdata[DONE_BIT];
    end
  end

  // set has priority over the write-one-to-clear
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_q <= 1'b0;
    end else if (done_set) begin
      done_q <= 1'b1;
    end else if (clr_wr) begin
      done_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result_q <= '0;
    end else if (cap_en) begin
      result_q <= cap_data;
    end
  end

  logic [CTRL_W-1:0] ctrl_word;
  assign ctrl_word = {dly_q, mask_q, sel_q, start_q};

  always_comb begin
    host_rdata = '0;
    case (host_addr)
      A_CTRL:   host_rdata = REG_W'(ctrl_word);
      A_STATUS: host_rdata[DONE_BIT] = done_q;
      A_IRQEN:  host_rdata[DONE_BIT] = ie_q;
      A_RESULT: host_rdata = REG_W'(result_q);
      A_RES_OB: host_rdata = REG_W'(result_q ^ (DATA_W'(1) << (DATA_W - 1)));
      default:  host_rdata = '0;
    endcase
  end

  assign start_pend = start_q;
  assign sel        = sel_q;
  assign mask       = mask_q;
  assign dly_req    = dly_q;
  assign done_flag  = done_q;
  assign ie_done    = ie_q;
  assign result_val = result_q;
  assign irq        = done_q && ie_q;

endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
  import adc_seq_pkg::*;
#(
  parameter int NUM_IN        = 10,
  parameter int DATA_W        = 16,
  parameter int SEL_W         = 4,
  parameter int SETTLE_CYCLES = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_pend,
  input  logic [SEL_W-1:0]  sel,
  input  logic [NUM_IN-1:0] mask,
  input  logic              dly_req,
  output logic              launch,
  output logic              busy,
  output logic              done_set,
  output logic              cap_en,
  output logic [DATA_W-1:0] cap_data,
  output logic              conv_req_valid,
  input  logic              conv_req_ready,
  output logic [SEL_W-1:0]  conv_chan,
  input  logic              res_valid,
  output logic              res_ready,
  input  logic [DATA_W-1:0] res_data
);
  seq_state_e state_q, state_d;
  logic       en_hit;
  logic       tmr_load;
  logic       tmr_zero;

  // enable lookup; select values beyond the input count never hit
  always_comb begin
    en_hit = 1'b0;
    for (int i = 0; i < NUM_IN; i++) begin
      if (sel == SEL_W'(i)) en_hit = mask[i];
    end
  end

  adc_seq_settle #(.CYCLES(SETTLE_CYCLES)) u_settle (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (tmr_load),
    .run   (state_q == ST_SETTLE),
    .zero  (tmr_zero)
  );

  always_comb begin
    state_d  = state_q;
    launch   = 1'b0;
    done_set = 1'b0;
    cap_en   = 1'b0;
    tmr_load = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start_pend) begin
          launch = 1'b1;
          if (!en_hit) begin
            done_set = 1'b1;
          end else if (dly_req) begin
            tmr_load = 1'b1;
            state_d  = ST_SETTLE;
          end else begin
            state_d = ST_REQ;
          end
        end
      end
      ST_SETTLE: begin
        if (tmr_zero) state_d = ST_REQ;
      end
      ST_REQ: begin
        if (conv_req_ready) state_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (res_valid) begin
          cap_en   = 1'b1;
          done_set = 1'b1;
          state_d  = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign busy           = (state_q != ST_IDLE);
  assign conv_req_valid = (state_q == ST_REQ);
  assign res_ready      = (state_q == ST_WAIT);
  assign conv_chan      = sel;
  assign cap_data       = res_data;

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int NUM_IN        = 10,
  parameter int DATA_W        = 16,
  parameter int REG_W         = 16,
  parameter int SETTLE_CYCLES = 1000
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      host_wr,
  input  logic [ADDR_W-1:0]         host_addr,
  input  logic [REG_W-1:0]          host_wdata,
  output logic [REG_W-1:0]          host_rdata,
  output logic                      conv_req_valid,
  input  logic                      conv_req_ready,
  output logic [$clog2(NUM_IN)-1:0] conv_chan,
  input  logic                      res_valid,
  output logic                      res_ready,
  input  logic [DATA_W-1:0]         res_data,
  output logic                      irq
);
  localparam int SEL_W = $clog2(NUM_IN);

  logic              start_pend;
  logic [SEL_W-1:0]  sel;
  logic [NUM_IN-1:0] mask;
  logic              dly_req;
  logic              launch;
  logic              busy;
  logic              done_set;
  logic              cap_en;
  logic [DATA_W-1:0] cap_data;
  logic              done_flag;
  logic              ie_done;
  logic [DATA_W-1:0] result_val;

  adc_seq_regs #(
    .NUM_IN (NUM_IN),
    .DATA_W (DATA_W),
    .REG_W  (REG_W),
    .SEL_W  (SEL_W)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_wr    (host_wr),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata),
    .start_pend (start_pend),
    .sel        (sel),
    .mask       (mask),
    .dly_req    (dly_req),
    .launch     (launch),
    .busy       (busy),
    .done_set   (done_set),
    .cap_en     (cap_en),
    .cap_data   (cap_data),
    .done_flag  (done_flag),
    .ie_done    (ie_done),
    .result_val (result_val),
    .irq        (irq)
  );

  adc_seq_fsm #(
    .NUM_IN        (NUM_IN),
    .DATA_W        (DATA_W),
    .SEL_W         (SEL_W),
    .SETTLE_CYCLES (SETTLE_CYCLES)
  ) u_fsm (
    .clk            (clk),
    .rst_n          (rst_n),
    .start_pend     (start_pend),
    .sel            (sel),
    .mask           (mask),
    .dly_req        (dly_req),
    .launch         (launch),
    .busy           (busy),
    .done_set       (done_set),
    .cap_en         (cap_en),
    .cap_data       (cap_data),
    .conv_req_valid (conv_req_valid),
    .conv_req_ready (conv_req_ready),
    .conv_chan      (conv_chan),
    .res_valid      (res_valid),
    .res_ready      (res_ready),
    .res_data       (res_data)
  );

endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk #(
  parameter int NUM_IN = 10,
  parameter int DATA_W = 16,
  parameter int REG_W  = 16,
  parameter int SEL_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_wr,
  input logic [2:0]        host_addr,
  input logic [REG_W-1:0]  host_wdata,
  input logic              conv_req_valid,
  input logic              conv_req_ready,
  input logic [SEL_W-1:0]  conv_chan,
  input logic              res_valid,
  input logic              res_ready,
  input logic [DATA_W-1:0] res_data,
  input logic              irq,
  input logic              done_flag,
  input logic              done_set,
  input logic              ie_done,
  input logic [NUM_IN-1:0] mask,
  input logic [DATA_W-1:0] result_val
);
  logic chan_enabled;
  assign chan_enabled = |(mask & (NUM_IN'(1) << conv_chan));

  p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_req_valid && !conv_req_ready) |=> (conv_req_valid && $stable(conv_chan)));

  p_one_in_flight_r5: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req_valid |-> !res_ready);

  p_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_ready) |=> (done_flag && (result_val == $past(res_data))));

  p_enabled_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req_valid |-> chan_enabled);

  p_result_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(res_valid && res_ready) |=> $stable(result_val));

  p_w1c_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && (host_addr == 3'd1) && host_wdata[2] && !done_set) |=> !done_flag);

  p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_set |=> done_flag);

  p_irq_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (done_flag && ie_done));

endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk #(
  .NUM_IN (NUM_IN),
  .DATA_W (DATA_W),
  .REG_W  (REG_W),
  .SEL_W  (SEL_W)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .host_wr        (host_wr),
  .host_addr      (host_addr),
  .host_wdata     (host_wdata),
  .conv_req_valid (conv_req_valid),
  .conv_req_ready (conv_req_ready),
  .conv_chan      (conv_chan),
  .res_valid      (res_valid),
  .res_ready      (res_ready),
  .res_data       (res_data),
  .irq            (irq),
  .done_flag      (done_flag),
  .done_set       (done_set),
  .ie_done        (ie_done),
  .mask           (mask),
  .result_val     (result_val)
);

// File: tb/adc_seq_ctrl_tb.sv
`timescale 1ns/1ps
module adc_seq_ctrl_tb;
  localparam int SETTLE = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr = 1'b0;
  logic [2:0]  host_addr = 3'd0;
  logic [15:0] host_wdata = 16'd0;
  logic [15:0] host_rdata;
  logic        conv_req_valid;
  logic        conv_req_ready = 1'b0;
  logic [3:0]  conv_chan;
  logic        res_valid = 1'b0;
  logic        res_ready;
  logic [15:0] res_data = 16'd0;
  logic        irq;

  always #4 clk = ~clk;

  adc_seq_ctrl #(.SETTLE_CYCLES(SETTLE)) u_dut (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .conv_req_valid(conv_req_valid), .conv_req_ready(conv_req_ready),
    .conv_chan(conv_chan), .res_valid(res_valid), .res_ready(res_ready),
    .res_data(res_data), .irq(irq)
  );

  int n_vec = 0;
  int n_err = 0;
  int stall_cyc = 0;
  int lat_cyc = 1;
  logic [15:0] next_data = 16'd0;
  logic [3:0]  exp_chan_q[$];
  logic [15:0] exp_res_q[$];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] mk(input int sel, input logic [9:0] m, input bit dly, input bit st);
    return {dly, m, 4'(sel), st};
  endfunction

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] v);
    host_addr = a;
    #1;
    v = host_rdata;
  endtask

  task automatic wait_done(input string req);
    logic [15:0] v;
    bit seen = 0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      rd(3'd1, v);
      if (v[2]) begin seen = 1; break; end
    end
    chk(seen, req, 32'(seen), 32'd1);
  endtask

  // converter model: request/result handshake with programmable stalls
  initial begin
    logic [3:0] held;
    forever begin
      @(negedge clk);
      if (conv_req_valid) begin
        held = conv_chan;
        for (int s = 0; s < stall_cyc; s++) begin
          @(negedge clk);
          chk(conv_req_valid && conv_chan == held, "R4 request held under back-pressure",
              {conv_req_valid, conv_chan}, {1'b1, held});
        end
        if (exp_chan_q.size() == 0) begin
          chk(1'b0, "R7/R9 unexpected conversion request", 32'(conv_chan), 32'hFFFF);
        end else begin
          logic [3:0] e;
          e = exp_chan_q.pop_front();
          chk(conv_chan == e, "R2 requested input number", 32'(conv_chan), 32'(e));
        end
        conv_req_ready = 1'b1;
        @(negedge clk);
        conv_req_ready = 1'b0;
        for (int l = 0; l < lat_cyc; l++) @(negedge clk);
        res_data = next_data;
        res_valid = 1'b1;
        while (!res_ready) @(negedge clk);
        exp_res_q.push_back(next_data);
        @(negedge clk);
        res_valid = 1'b0;
      end
    end
  end

  task automatic measure_launch(output int n);
    n = 0;
    for (int i = 0; i < 200; i++) begin
      if (conv_req_valid) break;
      @(negedge clk);
      n++;
    end
  endtask

  task automatic check_result(input logic [15:0] exp_val, input string req);
    logic [15:0] v;
    logic [15:0] e;
    if (exp_res_q.size() == 0) begin
      chk(1'b0, "R5 result missing", 32'd0, 32'(exp_val));
    end else begin
      e = exp_res_q.pop_front();
      rd(3'd3, v);
      chk(v == e && v == exp_val, req, 32'(v), 32'(exp_val));
    end
  endtask

  initial begin
    logic [15:0] v;
    int n0;
    int n1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(3'd0, v); chk(v == 16'h0, "R1 control after reset", 32'(v), 32'h0);
    rd(3'd1, v); chk(v == 16'h0, "R1 status after reset", 32'(v), 32'h0);
    rd(3'd2, v); chk(v == 16'h0, "R1 irq enable after reset", 32'(v), 32'h0);
    rd(3'd3, v); chk(v == 16'h0, "R1 result after reset", 32'(v), 32'h0);
    rd(3'd4, v); chk(v == 16'h8000, "R1 offset view after reset", 32'(v), 32'h8000);
    chk(!conv_req_valid && !res_ready && !irq, "R1 outputs low after reset",
        {conv_req_valid, res_ready, irq}, 32'h0);

    wr(3'd2, 16'h0004);

    // R2/R3/R5/R6/R11 plain conversion on input 3
    next_data = 16'h7FFF; stall_cyc = 0; lat_cyc = 2;
    exp_chan_q.push_back(4'd3);
    wr(3'd0, mk(3, 10'b1 << 3, 0, 1));
    measure_launch(n0);
    chk(n0 == 1, "R2 undelayed launch latency", 32'(n0), 32'd1);
    wait_done("R5 done after result");
    check_result(16'h7FFF, "R5 captured result");
    rd(3'd4, v); chk(v == 16'hFFFF, "R6 offset binary of 0x7FFF", 32'(v), 32'hFFFF);
    rd(3'd0, v); chk(v == mk(3, 10'b1 << 3, 0, 0), "R3 start self-clears, fields kept", 32'(v), 32'(mk(3, 10'b1 << 3, 0, 0)));
    chk(irq, "R11 irq with done and enable", 32'(irq), 32'd1);
    wr(3'd1, 16'h0000);
    rd(3'd1, v); chk(v[2], "R10 writing zero keeps done", 32'(v), 32'h4);
    wr(3'd1, 16'h0004);
    rd(3'd1, v); chk(!v[2], "R10 writing one clears done", 32'(v), 32'h0);
    chk(!irq, "R11 irq drops with done", 32'(irq), 32'd0);

    // R4 reference input 9 with request back-pressure
    next_data = 16'h8000; stall_cyc = 3; lat_cyc = 1;
    exp_chan_q.push_back(4'd9);
    wr(3'd0, mk(9, 10'h3FF, 0, 1));
    wait_done("R4 done after stalled request");
    check_result(16'h8000, "R5 captured result after stall");
    rd(3'd4, v); chk(v == 16'h0000, "R6 offset binary of 0x8000", 32'(v), 32'h0);
    wr(3'd1, 16'h0004);

    // R8 settling delay on input 0
    next_data = 16'h1234; stall_cyc = 0; lat_cyc = 1;
    exp_chan_q.push_back(4'd0);
    wr(3'd0, mk(0, 10'b1, 1, 1));
    measure_launch(n1);
    chk(n1 == n0 + SETTLE, "R8 delayed launch latency", 32'(n1), 32'(n0 + SETTLE));
    wait_done("R8 done after delayed conversion");
    check_result(16'h1234, "R8 result after delay");
    wr(3'd1, 16'h0004);

    // R7 disabled input: select 5, only input 4 enabled
    wr(3'd0, mk(5, 10'b1 << 4, 0, 1));
    wait_done("R7 done for disabled input");
    rd(3'd3, v); chk(v == 16'h1234, "R7 result unchanged (disabled)", 32'(v), 32'h1234);
    chk(exp_res_q.size() == 0, "R7 no conversion (disabled)", 32'(exp_res_q.size()), 32'd0);
    wr(3'd1, 16'h0004);

    // R7 select beyond range with full mask
    wr(3'd0, mk(12, 10'h3FF, 0, 1));
    wait_done("R7 done for out-of-range select");
    rd(3'd3, v); chk(v == 16'h1234, "R7 result unchanged (out of range)", 32'(v), 32'h1234);
    wr(3'd1, 16'h0004);

    // R9 control write while busy
    next_data = 16'h0F0F; lat_cyc = 10;
    exp_chan_q.push_back(4'd2);
    wr(3'd0, mk(2, 10'b1 << 2, 0, 1));
    repeat (3) @(negedge clk);
    wr(3'd0, mk(7, 10'b1 << 7, 0, 1));
    wait_done("R9 first conversion completes");
    check_result(16'h0F0F, "R9 result of first conversion");
    rd(3'd0, v); chk(v == mk(2, 10'b1 << 2, 0, 0), "R9 control kept after busy write", 32'(v), 32'(mk(2, 10'b1 << 2, 0, 0)));
    wr(3'd1, 16'h0004);
    repeat (30) @(negedge clk);
    rd(3'd1, v); chk(!v[2], "R9 no second conversion", 32'(v), 32'h0);

    // R11 interrupt masked
    wr(3'd2, 16'h0000);
    next_data = 16'hA5A5; lat_cyc = 1;
    exp_chan_q.push_back(4'd8);
    wr(3'd0, mk(8, 10'b1 << 8, 0, 1));
    wait_done("R11 done with irq masked");
    chk(!irq, "R11 irq low when disabled", 32'(irq), 32'd0);
    check_result(16'hA5A5, "R5 reference input 8 result");

    repeat (5) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end

endmodule